// File: doc/BRIEF.md
# Dual-Sided Inter-Processor Mailbox

This block connects two processors, side A and side B, through a pair of mirrored 32-bit register ports. Each side owns four outgoing data registers, four incoming data registers, a status word and a control word. A word that one side places in its outgoing register n appears in the peer's incoming register n. A full/empty handshake tracks each word until the peer has read it.

Next to the data channels, each side can ring any of four doorbells on the other side. Each doorbell raises a pending flag that the receiver later clears. Every status flag has an enable bit at the same position in the control word. A side's single interrupt line is the OR of all its enabled flags.

Register reads return data in the same cycle from the address alone. Side effects (clearing a full flag on a read, storing on a write) take place at the clock edge that ends the access. Both sides share one clock.

Top module: `ipc_mailbox`

## Requirements
- R1: Byte offsets are the same on both sides. Outgoing register n is at 0x00+4n and incoming register n at 0x10+4n, for n from 0 to 3. The status word is at 0x20 and the control word at 0x24. Any other or misaligned address reads zero, and a write to it has no effect. A write to an incoming register is ignored.
- R2: A word written to outgoing register n on one side reads back from the peer's incoming register n. It also reads back from the writer's own outgoing register n.
- R3: Status bit 23-n is outgoing-empty n and bit 27-n is incoming-full n. A write to outgoing n clears the writer's bit 23-n and sets the peer's bit 27-n. A peer read of incoming n clears the peer's bit 27-n and sets the writer's bit 23-n.
- R4: After reset both status words read 0x00F00000, both control words read 0, both interrupts are low and all data registers read 0.
- R5: Writing 1 to control bit 19-n raises status bit 31-n (doorbell pending n) on the peer. The flag is readable from the second clock edge after the write.
- R6: The doorbell request bit reads 1 for one cycle after the write, then clears by itself once the peer's flag is set.
- R7: Writing 1 to status bit 31-n clears the writer's doorbell pending n. Writing 0 leaves it unchanged. All other status bits ignore writes.
- R8: When a doorbell arrives in the same cycle as a write that clears that flag, the flag ends up set.
- R9: Control bits 31 to 20 are enables at the positions of the status flags. A side's interrupt is high exactly when some status flag and its enable are both 1.
- R10: Accesses by the two sides in the same cycle are handled independently. When a write to outgoing n coincides with the peer's read of incoming n, the full flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rstN | input | 1 | Active-low synchronous reset |
| aWrEn | input | 1 | Side A write strobe |
| aRdEn | input | 1 | Side A read strobe (for read side effects) |
| aAddr | input | ADDR_W | Side A byte address |
| aWdata | input | 32 | Side A write data |
| aRdata | output | 32 | Side A read data |
| aIrq | output | 1 | Side A interrupt |
| bWrEn | input | 1 | Side B write strobe |
| bRdEn | input | 1 | Side B read strobe (for read side effects) |
| bAddr | input | ADDR_W | Side B byte address |
| bWdata | input | 32 | Side B write data |
| bRdata | output | 32 | Side B read data |
| bIrq | output | 1 | Side B interrupt |

## Verification
The assertions assume each side presents at most one access per cycle, with the address held steady while a strobe is high. The stimulus tasks drive each port at the falling edge and release the strobe one cycle later to keep within this. The one-shot doorbell property allows a new control write to set the request again. The emptying property excludes a same-cycle write by the owner, so the deliberate collisions of R8 and R10 that the bench drives stay legal.

// File: rtl/ipcmbx_pkg.sv
package ipcmbx_pkg;
  localparam int CH = 4;
  localparam int DATA_W = 32;
  localparam int PEND_BASE = 28;
  localparam int FULL_BASE = 24;
  localparam int EMPTY_BASE = 20;
  localparam int REQ_BASE = 16;
  localparam int RX_WORD = CH;
  localparam int STAT_WORD = 2 * CH;
  localparam int CTRL_WORD = 2 * CH + 1;
  localparam logic [DATA_W-1:0] EN_MASK = {{(DATA_W-EMPTY_BASE){1'b1}}, {EMPTY_BASE{1'b0}}};

  typedef struct packed {
    logic [CH-1:0] txWr;
    logic [CH-1:0] rxRd;
    logic ctrlWr;
    logic statWr;
  } mbx_strobe_t;
endpackage

// File: rtl/ipcmbx_decode.sv
module ipcmbx_decode
  import ipcmbx_pkg::*;
#(
  parameter int ADDR_W = 6,
  localparam int IDX_W = ADDR_W - 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic [1:0] wrEn,
  input  logic [1:0] rdEn,
  input  logic [1:0][ADDR_W-1:0] addr,
  output mbx_strobe_t [1:0] strb,
  output logic [1:0][IDX_W-1:0] rdWord,
  output logic [1:0] rdValid
);
  for (genvar s = 0; s < 2; s++) begin : g_side
    logic [IDX_W-1:0] idx;
    logic valid;
    assign idx = addr[s][ADDR_W-1:2];
    assign valid = (addr[s][1:0] == 2'b00) && (int'(idx) <= CTRL_WORD);
    assign rdWord[s] = idx;
    assign rdValid[s] = valid;

    always_comb begin
      strb[s] = '0;
      for (int n = 0; n < CH; n++) begin
        strb[s].txWr[n] = wrEn[s] && valid && (int'(idx) == n);
        strb[s].rxRd[n] = rdEn[s] && valid && (int'(idx) == RX_WORD + n);
      end
      strb[s].statWr = wrEn[s] && valid && (int'(idx) == STAT_WORD);
      strb[s].ctrlWr = wrEn[s] && valid && (int'(idx) == CTRL_WORD);
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0({strb[s].txWr, strb[s].rxRd, strb[s].ctrlWr, strb[s].statWr})); // R1
  end
endmodule

// File: rtl/ipcmbx_datapath.sv
module ipcmbx_datapath
  import ipcmbx_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic clk,
  input  logic rstN,
  input  mbx_strobe_t [1:0] strb,
  input  logic [1:0][DATA_W-1:0] wdata,
  input  logic [1:0][IDX_W-1:0] rdWord,
  input  logic [1:0] rdValid,
  output logic [1:0][DATA_W-1:0] rdata,
  output logic [1:0] irq
);
  logic [1:0][CH-1:0][DATA_W-1:0] txData;
  logic [1:0][CH-1:0] full;
  logic [1:0][CH-1:0] pend;
  logic [1:0][CH-1:0] req;
  logic [1:0][DATA_W-1:0] ctrlReg;
  logic [1:0][DATA_W-1:0] stat;
  logic [1:0][DATA_W-1:0] ctrlView;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txData <= '0;
      full <= '0;
      pend <= '0;
      req <= '0;
      ctrlReg <= '0;
    end else begin
      for (int s = 0; s < 2; s++) begin
        for (int n = 0; n < CH; n++) begin
          if (strb[s].txWr[n]) txData[s][n] <= wdata[s];
          if (strb[s].txWr[n]) full[s][n] <= 1'b1;
          else if (strb[1-s].rxRd[n]) full[s][n] <= 1'b0;
          if (req[1-s][n]) pend[s][n] <= 1'b1;
          else if (strb[s].statWr && wdata[s][PEND_BASE+CH-1-n]) pend[s][n] <= 1'b0;
          req[s][n] <= strb[s].ctrlWr && wdata[s][REQ_BASE+CH-1-n];
        end
        if (strb[s].ctrlWr) ctrlReg[s] <= wdata[s] & EN_MASK;
      end
    end
  end

  always_comb begin
    for (int s = 0; s < 2; s++) begin
      stat[s] = '0;
      ctrlView[s] = ctrlReg[s];
      for (int n = 0; n < CH; n++) begin
        stat[s][PEND_BASE+CH-1-n] = pend[s][n];
        stat[s][FULL_BASE+CH-1-n] = full[1-s][n];
        stat[s][EMPTY_BASE+CH-1-n] = !full[s][n];
        ctrlView[s][REQ_BASE+CH-1-n] = req[s][n];
      end
    end
  end

  always_comb begin
    for (int s = 0; s < 2; s++) begin
      rdata[s] = '0;
      if (rdValid[s]) begin
        for (int n = 0; n < CH; n++) begin
          if (int'(rdWord[s]) == n) rdata[s] = txData[s][n];
          if (int'(rdWord[s]) == RX_WORD + n) rdata[s] = txData[1-s][n];
        end
        if (int'(rdWord[s]) == STAT_WORD) rdata[s] = stat[s];
        if (int'(rdWord[s]) == CTRL_WORD) rdata[s] = ctrlView[s];
      end
      irq[s] = |(stat[s] & ctrlReg[s]);
    end
  end

  for (genvar s = 0; s < 2; s++) begin : g_chk
    localparam int P = 1 - s;
    for (genvar n = 0; n < CH; n++) begin : g_ch
      AST_TX_MARKS_FULL: assert property (@(posedge clk) disable iff (!rstN)
        strb[s].txWr[n] |=> (!stat[s][EMPTY_BASE+CH-1-n] && stat[P][FULL_BASE+CH-1-n])); // R3
      AST_READ_FREES: assert property (@(posedge clk) disable iff (!rstN)
        (strb[P].rxRd[n] && !strb[s].txWr[n]) |=> stat[s][EMPTY_BASE+CH-1-n]); // R3
      AST_REQ_DELIVERS: assert property (@(posedge clk) disable iff (!rstN)
        req[s][n] |=> stat[P][PEND_BASE+CH-1-n]); // R5
      AST_REQ_ONE_SHOT: assert property (@(posedge clk) disable iff (!rstN)
        (req[s][n] && !strb[s].ctrlWr) |=> !ctrlView[s][REQ_BASE+CH-1-n]); // R6
      AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
        (stat[s][PEND_BASE+CH-1-n] && !strb[s].statWr) |=> stat[s][PEND_BASE+CH-1-n]); // R7
    end
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
      irq[s] |-> ((stat[s] & EN_MASK) != '0)); // R9
  end
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import ipcmbx_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic clk,
  input  logic rstN,
  input  logic aWrEn,
  input  logic aRdEn,
  input  logic [ADDR_W-1:0] aAddr,
  input  logic [DATA_W-1:0] aWdata,
  output logic [DATA_W-1:0] aRdata,
  output logic aIrq,
  input  logic bWrEn,
  input  logic bRdEn,
  input  logic [ADDR_W-1:0] bAddr,
  input  logic [DATA_W-1:0] bWdata,
  output logic [DATA_W-1:0] bRdata,
  output logic bIrq
);
  localparam int IDX_W = ADDR_W - 2;

  mbx_strobe_t [1:0] strb;
  logic [1:0][IDX_W-1:0] rdWord;
  logic [1:0] rdValid;
  logic [1:0][DATA_W-1:0] rdata;
  logic [1:0] irq;

  ipcmbx_decode #(.ADDR_W(ADDR_W)) u_decode (
    .clk(clk), .rstN(rstN),
    .wrEn({bWrEn, aWrEn}), .rdEn({bRdEn, aRdEn}), .addr({bAddr, aAddr}),
    .strb(strb), .rdWord(rdWord), .rdValid(rdValid)
  );

  ipcmbx_datapath #(.IDX_W(IDX_W)) u_datapath (
    .clk(clk), .rstN(rstN), .strb(strb), .wdata({bWdata, aWdata}),
    .rdWord(rdWord), .rdValid(rdValid), .rdata(rdata), .irq(irq)
  );

  assign aRdata = rdata[0];
  assign bRdata = rdata[1];
  assign aIrq = irq[0];
  assign bIrq = irq[1];
endmodule

// File: tb/ipc_mailbox_tb.sv
module ipc_mailbox_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] wrEn = '0;
  logic [1:0] rdEn = '0;
  logic [5:0] addr [2];
  logic [31:0] wdata [2];
  logic [31:0] aRdata, bRdata;
  logic aIrq, bIrq;
  int nChecks = 0;
  int nFail = 0;

  always #4 clk = ~clk;

  ipc_mailbox u_dut (
    .clk(clk), .rstN(rstN),
    .aWrEn(wrEn[0]), .aRdEn(rdEn[0]), .aAddr(addr[0]), .aWdata(wdata[0]),
    .aRdata(aRdata), .aIrq(aIrq),
    .bWrEn(wrEn[1]), .bRdEn(rdEn[1]), .bAddr(addr[1]), .bWdata(wdata[1]),
    .bRdata(bRdata), .bIrq(bIrq)
  );

  // Vector: [39] side (0=A,1=B), [38] 1=read-and-compare, [37:32] address, [31:0] data or expected.
  // Covers R1 (address map), R2 (data crossing) and R3 (full/empty flags).
  localparam logic [39:0] VEC [15] = '{
    {1'b0, 1'b0, 6'h00, 32'h11111111},
    {1'b1, 1'b1, 6'h10, 32'h11111111},
    {1'b1, 1'b0, 6'h08, 32'hCAFEF00D},
    {1'b0, 1'b1, 6'h20, 32'h02F00000},
    {1'b0, 1'b1, 6'h18, 32'hCAFEF00D},
    {1'b0, 1'b1, 6'h20, 32'h00F00000},
    {1'b0, 1'b0, 6'h0C, 32'h0000ABCD},
    {1'b1, 1'b1, 6'h20, 32'h01F00000},
    {1'b0, 1'b1, 6'h20, 32'h00E00000},
    {1'b1, 1'b1, 6'h1C, 32'h0000ABCD},
    {1'b0, 1'b1, 6'h0C, 32'h0000ABCD},
    {1'b0, 1'b1, 6'h28, 32'h00000000},
    {1'b1, 1'b0, 6'h14, 32'hFFFFFFFF},
    {1'b1, 1'b1, 6'h14, 32'h00000000},
    {1'b0, 1'b1, 6'h20, 32'h00F00000}
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic doWrite(input int s, input logic [5:0] a, input logic [31:0] d);
    wrEn[s] = 1'b1; addr[s] = a; wdata[s] = d;
    @(posedge clk); @(negedge clk);
    wrEn[s] = 1'b0;
  endtask

  task automatic doRead(input int s, input logic [5:0] a, input logic [31:0] exp, input string tag);
    rdEn[s] = 1'b1; addr[s] = a;
    #1;
    check(tag, (s == 0) ? aRdata : bRdata, exp);
    @(posedge clk); @(negedge clk);
    rdEn[s] = 1'b0;
  endtask

  task automatic idle();
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    #(8 * 100000);
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    addr[0] = '0; addr[1] = '0; wdata[0] = '0; wdata[1] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R4 reset state
    check("R4 irq A", {31'b0, aIrq}, 32'h0);
    check("R4 irq B", {31'b0, bIrq}, 32'h0);
    doRead(0, 6'h20, 32'h00F00000, "R4 status A");
    doRead(1, 6'h20, 32'h00F00000, "R4 status B");
    doRead(1, 6'h24, 32'h0, "R4 control B");
    doRead(0, 6'h10, 32'h0, "R4 data A");

    for (int i = 0; i < 15; i++) begin
      if (VEC[i][38]) doRead(int'(VEC[i][39]), VEC[i][37:32], VEC[i][31:0], $sformatf("table row %0d", i));
      else doWrite(int'(VEC[i][39]), VEC[i][37:32], VEC[i][31:0]);
    end

    // R5 / R6 doorbell A -> B channel 1
    doWrite(0, 6'h24, 32'h00040000);
    doRead(0, 6'h24, 32'h00040000, "R6 request visible one cycle");
    doRead(1, 6'h20, 32'h40F00000, "R5 pending on peer");
    doRead(0, 6'h24, 32'h0, "R6 request cleared");
    check("R9 no enable, no irq", {31'b0, bIrq}, 32'h0);
    doWrite(1, 6'h24, 32'h40000000);
    check("R9 pending enabled", {31'b0, bIrq}, 32'h1);
    // R7 write-one-to-clear
    doWrite(1, 6'h20, 32'h0);
    doRead(1, 6'h20, 32'h40F00000, "R7 zero write keeps pending");
    doWrite(1, 6'h20, 32'hBFFFFFFF);
    doRead(1, 6'h20, 32'h40F00000, "R7 other bits ignored");
    doWrite(1, 6'h20, 32'h40000000);
    doRead(1, 6'h20, 32'h00F00000, "R7 clear");
    check("R9 irq drops", {31'b0, bIrq}, 32'h0);
    // R8 set wins over clear
    doWrite(0, 6'h24, 32'h00040000);
    doWrite(1, 6'h20, 32'h40000000);
    doRead(1, 6'h20, 32'h40F00000, "R8 arrival beats clear");
    doWrite(1, 6'h20, 32'h40000000);
    doWrite(1, 6'h24, 32'h0);
    // R5 reverse direction, channel 3
    doWrite(1, 6'h24, 32'h00010000);
    idle();
    doRead(0, 6'h20, 32'h10F00000, "R5 B to A pending");
    doWrite(0, 6'h20, 32'h10000000);

    // R9 empty and full enables
    doWrite(0, 6'h24, 32'h00800000);
    check("R9 empty enable", {31'b0, aIrq}, 32'h1);
    doWrite(0, 6'h00, 32'h12345678);
    check("R9 empty cleared", {31'b0, aIrq}, 32'h0);
    doWrite(1, 6'h24, 32'h08000000);
    check("R9 full enable", {31'b0, bIrq}, 32'h1);
    doRead(1, 6'h10, 32'h12345678, "R2 data B");
    check("R9 full cleared", {31'b0, bIrq}, 32'h0);
    check("R9 empty again", {31'b0, aIrq}, 32'h1);
    doWrite(0, 6'h24, 32'h0);
    check("R9 disabled", {31'b0, aIrq}, 32'h0);
    doWrite(1, 6'h24, 32'h0);

    // R10 simultaneous traffic
    fork
      doWrite(0, 6'h04, 32'hAAAA0001);
      doWrite(1, 6'h04, 32'hBBBB0001);
    join
    doRead(0, 6'h20, 32'h04B00000, "R10 status A");
    doRead(1, 6'h20, 32'h04B00000, "R10 status B");
    doRead(0, 6'h14, 32'hBBBB0001, "R10 data A");
    doRead(1, 6'h14, 32'hAAAA0001, "R10 data B");
    doWrite(0, 6'h08, 32'h00000001);
    fork
      doWrite(0, 6'h08, 32'h00000002);
      doRead(1, 6'h18, 32'h00000001, "R10 read during write");
    join
    doRead(1, 6'h20, 32'h02F00000, "R10 full kept");
    doRead(1, 6'h18, 32'h00000002, "R10 new word");

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule